// File: doc/BRIEF.md
# Function Power-State Access Gate

This block sits between the bus target of a peripheral function and that function's internal register spaces. It holds the function's two-bit power-state field and applies the access and interrupt rules for that state. In full-on it is transparent. Every bus request goes through one cycle later, and the interrupt line follows the enabled, pending sources. In the deepest sleep state it lets only configuration-space requests through. It answers memory-space and I/O-space requests with a master-abort, and it holds the interrupt line low.

The power-state field is written by a configuration write to a fixed register address, and it is read back on a port. While the function sleeps, the block releases the port drive enable and reports that no device is attached.

On waking, no reset is applied, because none is needed. The interrupt sources and enables live outside the gate and are only masked, not cleared. A source that is still pending therefore raises the interrupt as soon as full-on returns. The first request after waking is forwarded with its whole payload.

Top module: `pwr_access_gate`

## Requirements
- R1: A configuration-space request (space code 2'b00) is forwarded one cycle later with no abort, whatever the power state.
- R2: In power state 2'b11, a request with space code 2'b01 (memory), 2'b10 (I/O) or the unused code 2'b11 is not forwarded; `abortValid` pulses for one cycle, one cycle after the request.
- R3: In power states 2'b00, 2'b01 and 2'b10, memory and I/O requests are forwarded one cycle later and are never aborted.
- R4: While the power state is 2'b11, `irqOut` is low even when a source is both pending and enabled.
- R5: Outside state 2'b11, `irqOut` is the registered OR of `irqStatus & irqEnable`. A source left pending through sleep raises `irqOut` once full-on returns.
- R6: While the power state is 2'b11, `portDriveOut` and `devPresentOut` are low. Otherwise they follow `portDriveIn` and `devPresentIn` one cycle later.
- R7: A configuration write to address `PM_ADDR` loads `reqWdata[1:0]` into the power state at the end of its cycle. The write itself, and the interrupt gating of that cycle, use the old state. Configuration writes to any other address leave the state unchanged.
- R8: Waking from 2'b11 to 2'b00 applies no reset, and a memory request in the very next cycle is forwarded.
- R9: After reset the power state is 2'b00, and `fwdValid`, `abortValid`, `irqOut`, `portDriveOut` and `devPresentOut` are low.
- R10: A forwarded request carries its space, write flag, address and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus request present this cycle |
| reqSpace | input | 2 | 00 configuration, 01 memory, 10 I/O, 11 unused |
| reqWrite | input | 1 | Request is a write |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| fwdValid | output | 1 | Forwarded request valid |
| fwdSpace | output | 2 | Forwarded space code |
| fwdWrite | output | 1 | Forwarded write flag |
| fwdAddr | output | ADDR_W | Forwarded address |
| fwdWdata | output | DATA_W | Forwarded write data |
| abortValid | output | 1 | Master-abort response pulse |
| irqStatus | input | NSRC | Pending interrupt sources |
| irqEnable | input | NSRC | Interrupt source enables |
| irqOut | output | 1 | Gated interrupt line |
| portDriveIn | input | 1 | Port drive enable from the function |
| devPresentIn | input | 1 | Device-attached indication from the port |
| portDriveOut | output | 1 | Gated port drive enable |
| devPresentOut | output | 1 | Reported device-attached status |
| pwrState | output | 2 | Current power-state field |

## Verification
Two functions can fall in the same cycle: a power-state write and the interrupt gating. The bench provokes this with a configuration write that enters or leaves state 2'b11 while an enabled source is pending. It then checks that `irqOut` keeps its old value in the sample right after the write and changes only in the next one. The same collision is provoked for request gating: a memory request issued in the cycle right after a sleep or wake write must be judged against the new state.

// File: rtl/pag_pkg.sv
package pag_pkg;

  typedef enum logic [1:0] {
    SPACE_CFG  = 2'b00,
    SPACE_MEM  = 2'b01,
    SPACE_IO   = 2'b10,
    SPACE_RSVD = 2'b11
  } space_e;

  localparam logic [1:0] PS_FULL_ON    = 2'b00;
  localparam logic [1:0] PS_DEEP_SLEEP = 2'b11;

  typedef struct packed {
    logic fwd;
    logic abort;
    logic sleep;
  } gate_strobe_t;

endpackage

// File: rtl/pag_ctrl.sv
module pag_ctrl
  import pag_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PM_ADDR = 12'h044
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqSpace,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqField,
  output gate_strobe_t      strobe,
  output logic [1:0]        pwrState
);

  logic isCfg;
  logic stateWrite;
  logic inSleep;

  assign isCfg      = (space_e'(reqSpace) == SPACE_CFG);
  assign inSleep    = (pwrState == PS_DEEP_SLEEP);
  assign stateWrite = reqValid && isCfg && reqWrite && (reqAddr == PM_ADDR);

  // The new state is taken at the end of the write cycle, so the request of
  // that cycle and the interrupt gating of that cycle still see the old one.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrState <= PS_FULL_ON;
    end else if (stateWrite) begin
      pwrState <= reqField;
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.sleep = inSleep;
    strobe.fwd   = reqValid && (isCfg || !inSleep);
    strobe.abort = reqValid && !isCfg && inSleep;
  end

endmodule

// File: rtl/pag_dp.sv
module pag_dp
  import pag_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NSRC   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gate_strobe_t      strobe,
  input  logic [1:0]        reqSpace,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [NSRC-1:0]   irqStatus,
  input  logic [NSRC-1:0]   irqEnable,
  input  logic              portDriveIn,
  input  logic              devPresentIn,
  output logic              fwdValid,
  output logic [1:0]        fwdSpace,
  output logic              fwdWrite,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdWdata,
  output logic              abortValid,
  output logic              irqOut,
  output logic              portDriveOut,
  output logic              devPresentOut
);

  logic [NSRC-1:0] liveSrc;
  logic            anyLive;

  assign liveSrc = irqStatus & irqEnable;
  assign anyLive = |liveSrc;

  // Handshake flags: cleared by reset.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid      <= 1'b0;
      abortValid    <= 1'b0;
      irqOut        <= 1'b0;
      portDriveOut  <= 1'b0;
      devPresentOut <= 1'b0;
    end else begin
      fwdValid      <= strobe.fwd;
      abortValid    <= strobe.abort;
      irqOut        <= anyLive && !strobe.sleep;
      portDriveOut  <= portDriveIn && !strobe.sleep;
      devPresentOut <= devPresentIn && !strobe.sleep;
    end
  end

  // Payload registers: loaded only for forwarded requests, no reset needed.
  always_ff @(posedge clk) begin
    if (strobe.fwd) begin
      fwdSpace <= reqSpace;
      fwdWrite <= reqWrite;
      fwdAddr  <= reqAddr;
      fwdWdata <= reqWdata;
    end
  end

endmodule

// File: rtl/pwr_access_gate.sv
module pwr_access_gate
  import pag_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NSRC   = 8,
  parameter logic [ADDR_W-1:0] PM_ADDR = 12'h044
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqSpace,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              fwdValid,
  output logic [1:0]        fwdSpace,
  output logic              fwdWrite,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdWdata,
  output logic              abortValid,
  input  logic [NSRC-1:0]   irqStatus,
  input  logic [NSRC-1:0]   irqEnable,
  output logic              irqOut,
  input  logic              portDriveIn,
  input  logic              devPresentIn,
  output logic              portDriveOut,
  output logic              devPresentOut,
  output logic [1:0]        pwrState
);

  gate_strobe_t strobe;

  pag_ctrl #(.ADDR_W(ADDR_W), .PM_ADDR(PM_ADDR)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqSpace (reqSpace),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqField (reqWdata[1:0]),
    .strobe   (strobe),
    .pwrState (pwrState)
  );

  pag_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqSpace     (reqSpace),
    .reqWrite     (reqWrite),
    .reqAddr      (reqAddr),
    .reqWdata     (reqWdata),
    .irqStatus    (irqStatus),
    .irqEnable    (irqEnable),
    .portDriveIn  (portDriveIn),
    .devPresentIn (devPresentIn),
    .fwdValid     (fwdValid),
    .fwdSpace     (fwdSpace),
    .fwdWrite     (fwdWrite),
    .fwdAddr      (fwdAddr),
    .fwdWdata     (fwdWdata),
    .abortValid   (abortValid),
    .irqOut       (irqOut),
    .portDriveOut (portDriveOut),
    .devPresentOut(devPresentOut)
  );

endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NSRC   = 8,
  parameter logic [ADDR_W-1:0] PM_ADDR = 12'h044
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqSpace,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWdata,
  input logic              fwdValid,
  input logic              abortValid,
  input logic [NSRC-1:0]   irqStatus,
  input logic [NSRC-1:0]   irqEnable,
  input logic              irqOut,
  input logic              portDriveOut,
  input logic              devPresentOut,
  input logic [1:0]        pwrState
);

  assert_cfg_forward_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSpace == 2'b00) |=> (fwdValid && !abortValid));

  assert_sleep_abort_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSpace != 2'b00 && pwrState == 2'b11) |=> (abortValid && !fwdValid));

  assert_awake_forward_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && pwrState != 2'b11) |=> (fwdValid && !abortValid));

  assert_irq_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b11) |=> !irqOut);

  assert_irq_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState != 2'b11 && |(irqStatus & irqEnable)) |=> irqOut);

  assert_port_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'b11) |=> (!portDriveOut && !devPresentOut));

  assert_state_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSpace == 2'b00 && reqWrite && reqAddr == PM_ADDR)
      |=> (pwrState == $past(reqWdata[1:0])));

  assert_state_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqSpace == 2'b00 && reqWrite && reqAddr == PM_ADDR) |=> $stable(pwrState));

  assert_one_response_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdValid && abortValid));

endmodule

bind pwr_access_gate pag_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC), .PM_ADDR(PM_ADDR)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqSpace     (reqSpace),
  .reqWrite     (reqWrite),
  .reqAddr      (reqAddr),
  .reqWdata     (reqWdata),
  .fwdValid     (fwdValid),
  .abortValid   (abortValid),
  .irqStatus    (irqStatus),
  .irqEnable    (irqEnable),
  .irqOut       (irqOut),
  .portDriveOut (portDriveOut),
  .devPresentOut(devPresentOut),
  .pwrState     (pwrState)
);

// File: tb/pwr_access_gate_tb_top.sv
module pwr_access_gate_tb_top;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NSRC   = 8;
  localparam logic [ADDR_W-1:0] PM_ADDR = 12'h044;

  // Vector: {stateToSet[5:4], space[3:2], expFwd[1], expAbort[0]}
  localparam int NVEC = 10;
  localparam logic [5:0] VEC [NVEC] = '{
    {2'b00, 2'b01, 1'b1, 1'b0},
    {2'b00, 2'b10, 1'b1, 1'b0},
    {2'b00, 2'b00, 1'b1, 1'b0},
    {2'b11, 2'b01, 1'b0, 1'b1},
    {2'b11, 2'b10, 1'b0, 1'b1},
    {2'b11, 2'b00, 1'b1, 1'b0},
    {2'b01, 2'b01, 1'b1, 1'b0},
    {2'b10, 2'b10, 1'b1, 1'b0},
    {2'b11, 2'b11, 1'b0, 1'b1},
    {2'b00, 2'b11, 1'b1, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [1:0]        reqSpace = 2'b00;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              fwdValid;
  logic [1:0]        fwdSpace;
  logic              fwdWrite;
  logic [ADDR_W-1:0] fwdAddr;
  logic [DATA_W-1:0] fwdWdata;
  logic              abortValid;
  logic [NSRC-1:0]   irqStatus = '0;
  logic [NSRC-1:0]   irqEnable = '0;
  logic              irqOut;
  logic              portDriveIn = 1'b0;
  logic              devPresentIn = 1'b0;
  logic              portDriveOut;
  logic              devPresentOut;
  logic [1:0]        pwrState;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_access_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC), .PM_ADDR(PM_ADDR)) dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqSpace(reqSpace), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .fwdValid(fwdValid), .fwdSpace(fwdSpace), .fwdWrite(fwdWrite),
    .fwdAddr(fwdAddr), .fwdWdata(fwdWdata), .abortValid(abortValid),
    .irqStatus(irqStatus), .irqEnable(irqEnable), .irqOut(irqOut),
    .portDriveIn(portDriveIn), .devPresentIn(devPresentIn),
    .portDriveOut(portDriveOut), .devPresentOut(devPresentOut),
    .pwrState(pwrState)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drives one request for one cycle; returns at the sample point where the
  // registered response of that request is visible.
  task automatic access(input logic [1:0] sp, input logic wr,
                        input logic [ADDR_W-1:0] ad, input logic [DATA_W-1:0] wd);
    reqValid = 1'b1; reqSpace = sp; reqWrite = wr; reqAddr = ad; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    portDriveIn = 1'b1; devPresentIn = 1'b1;
    irqStatus = 8'hFF; irqEnable = 8'hFF;
    idle(3);
    check(pwrState == 2'b00, "R9 pwrState", pwrState, 0);
    check({fwdValid, abortValid, irqOut, portDriveOut, devPresentOut} == 5'b0,
          "R9 outputs", {fwdValid, abortValid, irqOut, portDriveOut, devPresentOut}, 0);
    irqStatus = '0; irqEnable = '0;
    rstN = 1'b1;
    idle(1);

    // Table walk: R1, R2, R3
    for (int i = 0; i < NVEC; i++) begin
      access(2'b00, 1'b1, PM_ADDR, {30'd0, VEC[i][5:4]});
      check(fwdValid && !abortValid, "R1 state write forwarded", {fwdValid, abortValid}, 2'b10);
      check(pwrState == VEC[i][5:4], "R7 state loaded", pwrState, VEC[i][5:4]);
      access(VEC[i][3:2], 1'b0, 12'h100 + ADDR_W'(i), '0);
      check(fwdValid == VEC[i][1] && abortValid == VEC[i][0],
            (VEC[i][3:2] == 2'b00) ? "R1 cfg access" :
            (VEC[i][5:4] == 2'b11) ? "R2 sleep abort" : "R3 awake forward",
            {fwdValid, abortValid}, VEC[i][1:0]);
      idle(1);
      check(!fwdValid && !abortValid, "R2 response is one pulse", {fwdValid, abortValid}, 0);
    end

    // R10: payload intact
    access(2'b00, 1'b1, PM_ADDR, 32'd0);
    access(2'b01, 1'b1, 12'h123, 32'hDEADBEEF);
    check(fwdValid && fwdSpace == 2'b01 && fwdWrite && fwdAddr == 12'h123,
          "R10 header", {fwdSpace, fwdWrite, fwdAddr}, {2'b01, 1'b1, 12'h123});
    check(fwdWdata == 32'hDEADBEEF, "R10 data", fwdWdata, 32'hDEADBEEF);

    // R5 / R6 in full-on
    irqStatus = 8'h04; irqEnable = 8'h00;
    idle(2);
    check(!irqOut, "R5 disabled source", irqOut, 0);
    irqEnable = 8'h04;
    idle(1);
    check(irqOut, "R5 enabled source", irqOut, 1);
    check(portDriveOut && devPresentOut, "R6 awake pass", {portDriveOut, devPresentOut}, 2'b11);

    // Enter sleep with source pending: old state in the write cycle (R7)
    access(2'b00, 1'b1, PM_ADDR, 32'd3);
    check(irqOut, "R7 irq uses old state in write cycle", irqOut, 1);
    idle(1);
    check(!irqOut, "R4 irq masked in sleep", irqOut, 0);
    check(!portDriveOut && !devPresentOut, "R6 port released", {portDriveOut, devPresentOut}, 0);

    // R7: write to another config address leaves state
    access(2'b00, 1'b1, 12'h010, 32'd0);
    check(pwrState == 2'b11, "R7 other address ignored", pwrState, 3);
    access(2'b10, 1'b1, 12'h020, 32'h55);
    check(abortValid && !fwdValid, "R2 io write aborted", {fwdValid, abortValid}, 2'b01);
    idle(2);
    check(!irqOut, "R4 still masked", irqOut, 0);

    // Wake: R5 pending interrupt returns, R8 immediate access
    access(2'b00, 1'b1, PM_ADDR, 32'd0);
    check(!irqOut, "R7 irq uses old state on wake", irqOut, 0);
    access(2'b01, 1'b0, 12'h2A0, 32'd0);
    check(fwdValid && !abortValid && fwdAddr == 12'h2A0, "R8 first access after wake",
          {fwdValid, abortValid, fwdAddr}, {2'b10, 12'h2A0});
    check(irqOut, "R5 pending irq after wake", irqOut, 1);
    check(portDriveOut && devPresentOut, "R6 port restored", {portDriveOut, devPresentOut}, 2'b11);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule